// File: doc/BRIEF.md
# I2C Target Byte Receiver with Two-Slot Store and Clock Stretching

This block is the receive path of an I2C target. A one-cycle arm strobe starts the capture of a single byte. The block samples eight data bits from SDA, most significant first, one on each SCL rising-event pulse. It then drives the acknowledge bit by enabling the SDA pull-down during the ninth clock. Edge detection, pad drivers and address matching sit outside the block. They supply single-cycle SCL rising and delayed-falling event pulses and a start/stop condition flag.

Finished bytes go into a two-slot store. The front slot drives the data output together with `out_valid`. A second slot behind it absorbs one more byte, and `out_ready` is low while that slot is occupied. The consumer takes the front byte with a one-cycle `take` strobe. A read armed while both slots are occupied does not start shifting. The block holds SCL low through `scl_hold` until a `take` frees a slot, and reception then proceeds.

Top module: `i2c_rx_hold`

## Requirements
- R1: During and after an active-low asynchronous reset, `out_valid`, `scl_hold` and `sda_pull` are 0 and `out_ready` is 1.
- R2: After `arm`, eight `scl_rise` pulses capture `sda_in` MSB first. When the acknowledge clock's `scl_fall` arrives and the front slot is empty, the byte appears on `out_byte` with `out_valid` 1 and `out_ready` 1 on the next cycle.
- R3: With `ack_en` high, `sda_pull` goes to 1 on the cycle after the eighth data bit's `scl_fall`. It stays 1 through the ninth `scl_rise` and returns to 0 on the cycle after the ninth `scl_fall`.
- R4: With `ack_en` low, `sda_pull` stays 0 through the ninth clock, and the byte is still stored.
- R5: A `take` while only one byte is held clears `out_valid` on the next cycle, and `out_ready` stays 1.
- R6: A byte that completes while the front byte is unconfirmed goes into the back slot. The front byte stays on `out_byte` with `out_valid` 1, and `out_ready` drops to 0.
- R7: An `arm` while both slots are full sets `scl_hold` on the next cycle. It stays 1 for every cycle without `take`.
- R8: A `take` while both slots are full moves the back byte to the output on the next cycle. `out_valid` stays 1, `out_ready` returns to 1 and `scl_hold` drops to 0. The stalled read then receives its byte normally.
- R9: `scl_hold` is never 1 while data bits are being shifted in.
- R10: A `bus_cond` pulse abandons a partly received byte, including one in its acknowledge phase. `sda_pull` drops on the next cycle, no byte is stored and bytes already held are kept. `scl_rise`/`scl_fall` pulses that follow without a new `arm` store nothing.
- R11: When a byte completes in the same cycle as a `take` of the only held byte, the new byte replaces it on the output. `out_valid` stays 1 and `out_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cond | input | 1 | Start or stop condition seen on the bus (one-cycle pulse) |
| ack_en | input | 1 | 1: acknowledge received bytes, 0: leave SDA released (NACK) |
| arm | input | 1 | One-cycle strobe that starts reception of one byte |
| scl_rise | input | 1 | One-cycle SCL rising-event pulse |
| scl_fall | input | 1 | One-cycle delayed SCL falling-event pulse |
| sda_in | input | 1 | Sampled SDA level |
| sda_pull | output | 1 | Enable for the SDA pull-down (acknowledge) |
| scl_hold | output | 1 | Request to hold SCL low (clock stretching) |
| out_valid | output | 1 | Front slot holds a byte |
| out_ready | output | 1 | Back slot is free |
| out_byte | output | W | Byte in the front slot |
| take | input | 1 | One-cycle strobe: consumer takes the front byte |

## Verification
Two functions can meet in one clock edge: a byte completing on the ninth `scl_fall`, and a consumer `take` of the front slot. The bench provokes this by raising `take` in the same cycle as the final falling pulse while a single byte is held. The scoreboard must see the old byte leave at that edge and the new byte replace it, with `out_valid` and `out_ready` both staying high. A second meeting point is a `take` during a stall. It must release `scl_hold` and promote the back byte in one cycle. Every taken byte is compared against the queue filled by the driver in arrival order.

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_cond,
  input  logic         ack_en,
  input  logic         arm,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         sda_in,
  output logic         sda_pull,
  output logic         scl_hold,
  output logic         out_valid,
  output logic         out_ready,
  output logic [W-1:0] out_byte,
  input  logic         take
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_STALL, S_SHIFT, S_ACKW, S_ACK} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  back_byte;
  logic          back_valid;
  logic          push;

  assign push      = (st == S_ACK) && scl_fall && !bus_cond;
  assign scl_hold  = (st == S_STALL);
  assign out_ready = !back_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      sda_pull <= 1'b0;
    end else if (bus_cond) begin
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (arm) begin
          st  <= back_valid ? S_STALL : S_SHIFT;
          cnt <= '0;
        end
        S_STALL: if (take) st <= S_SHIFT;
        S_SHIFT: if (scl_rise) begin
          sh  <= {sh[W-2:0], sda_in};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W-1)) st <= S_ACKW;
        end
        S_ACKW: if (scl_fall) begin
          sda_pull <= ack_en;
          st       <= S_ACK;
        end
        S_ACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_byte   <= '0;
      out_valid  <= 1'b0;
      back_byte  <= '0;
      back_valid <= 1'b0;
    end else if (push) begin
      if (!out_valid || take) begin
        out_byte  <= sh;
        out_valid <= 1'b1;
      end else begin
        back_byte  <= sh;
        back_valid <= 1'b1;
      end
    end else if (take && out_valid) begin
      if (back_valid) begin
        out_byte   <= back_byte;
        back_valid <= 1'b0;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  p_back_behind_front_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> out_valid);

  p_stretch_on_full_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> $past(arm) && !$past(out_ready));

  p_take_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold && take && !bus_cond |=> !scl_hold && out_valid && out_ready);

  p_no_stretch_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT || st == S_ACKW || st == S_ACK) |-> !scl_hold);

  p_cond_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cond |=> !sda_pull && !scl_hold);

  p_pull_drop_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) && !$past(bus_cond) |-> $past(scl_fall));

  p_swap_keeps_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push && take && out_valid |=> out_valid && out_ready);
endmodule

// File: tb/i2c_rx_hold_tb.sv
`timescale 1ns/1ps
module i2c_rx_hold_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cond = 0, ack_en = 1, arm = 0, scl_rise = 0, scl_fall = 0, sda_in = 0, take = 0;
  logic sda_pull, scl_hold, out_valid, out_ready;
  logic [7:0] out_byte;
  int errors = 0, checks = 0;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  i2c_rx_hold #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cond(bus_cond), .ack_en(ack_en), .arm(arm),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .sda_pull(sda_pull), .scl_hold(scl_hold), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .take(take));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (take && out_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R2 scoreboard: actual=%0h expected=none", out_byte);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (out_byte !== e) begin
          errors++;
          $display("FAIL R2 scoreboard: actual=%0h expected=%0h", out_byte, e);
        end
      end
    end
  end

  task automatic arm_rd();
    @(negedge clk) arm = 1;
    @(negedge clk) arm = 0;
  endtask

  task automatic pulse(input logic b);
    @(negedge clk) begin sda_in = b; scl_rise = 1; end
    @(negedge clk) begin scl_rise = 0; scl_fall = 1; end
    @(negedge clk) scl_fall = 0;
  endtask

  task automatic take_one();
    @(negedge clk) take = 1;
    @(negedge clk) take = 0;
  endtask

  task automatic rx_bits(input logic [7:0] d, input logic exp_ack, input logic take_last);
    logic seen;
    seen = 0;
    for (int i = 7; i >= 0; i--) begin
      pulse(d[i]);
      if (scl_hold) seen = 1;
    end
    chk(!seen, "R9 hold during shift", seen, 0);
    chk(sda_pull == exp_ack, exp_ack ? "R3 pull after bit8" : "R4 nack pull", sda_pull, exp_ack);
    expq.push_back(d);
    @(negedge clk) begin sda_in = 1; scl_rise = 1; end
    @(negedge clk) begin scl_rise = 0; scl_fall = 1; take = take_last; end
    chk(sda_pull == exp_ack, exp_ack ? "R3 pull through ack" : "R4 nack pull", sda_pull, exp_ack);
    @(negedge clk) begin scl_fall = 0; take = 0; end
    chk(sda_pull == 0, "R3 pull released", sda_pull, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1..all: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && scl_hold == 0 && sda_pull == 0, "R1 reset outputs low", {out_valid, scl_hold, sda_pull}, 0);
    chk(out_ready == 1, "R1 reset ready", out_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && out_ready == 1, "R1 after reset", {out_valid, out_ready}, 1);

    // R2 / R3 / R5 single byte
    arm_rd(); rx_bits(8'hD4, 1, 0);
    chk(out_valid == 1 && out_ready == 1, "R2 valid and ready", {out_valid, out_ready}, 3);
    chk(out_byte == 8'hD4, "R2 byte msb first", out_byte, 8'hD4);
    take_one();
    chk(out_valid == 0 && out_ready == 1, "R5 take clears valid", {out_valid, out_ready}, 1);

    // R6 / R7 / R8
    arm_rd(); rx_bits(8'h3C, 1, 0);
    arm_rd(); rx_bits(8'h81, 1, 0);
    chk(out_valid == 1 && out_ready == 0, "R6 second held", {out_valid, out_ready}, 2);
    chk(out_byte == 8'h3C, "R6 front kept", out_byte, 8'h3C);
    arm_rd();
    chk(scl_hold == 1, "R7 stretch on full arm", scl_hold, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(scl_hold == 1, "R7 stretch held", scl_hold, 1);
    end
    take_one();
    chk(out_valid == 1 && out_ready == 1 && scl_hold == 0, "R8 take releases", {out_valid, out_ready, scl_hold}, 6);
    chk(out_byte == 8'h81, "R8 back promoted", out_byte, 8'h81);
    rx_bits(8'h03, 1, 0);
    chk(out_ready == 0 && out_byte == 8'h81, "R8 stalled read completes", {out_ready, out_byte}, 9'h081);
    take_one(); take_one();
    chk(out_valid == 0 && out_ready == 1, "R5 drained", {out_valid, out_ready}, 1);

    // R4 nack
    ack_en = 0;
    arm_rd(); rx_bits(8'hA5, 0, 0);
    chk(out_valid == 1 && out_byte == 8'hA5, "R4 nack byte stored", out_byte, 8'hA5);
    take_one();
    ack_en = 1;

    // R10 abort
    arm_rd(); pulse(1); pulse(1); pulse(1);
    @(negedge clk) bus_cond = 1;
    @(negedge clk) bus_cond = 0;
    chk(sda_pull == 0 && out_valid == 0, "R10 partial dropped", {sda_pull, out_valid}, 0);
    arm_rd(); rx_bits(8'h5A, 1, 0);
    chk(out_byte == 8'h5A, "R10 fresh byte after abort", out_byte, 8'h5A);
    arm_rd();
    for (int i = 7; i >= 0; i--) pulse(1'(i & 1));
    chk(sda_pull == 1, "R3 pull before abort", sda_pull, 1);
    @(negedge clk) bus_cond = 1;
    @(negedge clk) bus_cond = 0;
    chk(sda_pull == 0, "R10 pull released", sda_pull, 0);
    pulse(1);
    chk(out_valid == 1 && out_ready == 1 && out_byte == 8'h5A, "R10 store kept", {out_valid, out_ready, out_byte}, 10'h35A);
    take_one();

    // R11 completion meets take
    arm_rd(); rx_bits(8'hE7, 1, 0);
    arm_rd(); rx_bits(8'h18, 1, 1);
    chk(out_valid == 1 && out_ready == 1, "R11 valid stays", {out_valid, out_ready}, 3);
    chk(out_byte == 8'h18, "R11 new byte on output", out_byte, 8'h18);
    take_one();
    chk(out_valid == 0, "R5 final empty", out_valid, 0);
    chk(expq.size() == 0, "R2 all bytes delivered", expq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule